// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the write port of a 16-bit voltage DAC. A host shifts 24-bit words into it over a three-wire serial link: an active-low frame-select, a serial clock and a data line. The receiver takes each bit on a falling serial-clock edge while frame-select is low. On the twenty-fourth such edge it loads the 16-bit conversion code and the 2-bit power-down mode together, and it pulses an update strobe for one system-clock cycle.

All three link inputs are brought into the system clock domain through two-flop synchronisers. Edges are then detected from the synchronised levels, so the system clock must run at least four times faster than the serial clock. If frame-select is raised before the twenty-fourth edge, the partial word is thrown away. The shift register and the edge counter return to empty, and neither output register changes. After a completed word the receiver ignores further clock edges until frame-select has gone high and low again.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset the code output is 0, the mode output is 00 (normal operation) and the update strobe is low.
- R2: Words arrive most significant bit first. Once a word completes, the code output equals word bits 15..0, with bit 15 as the code MSB.
- R3: Once a word completes, the mode output equals word bits 17..16, with bit 17 as the mode MSB. All four mode values are accepted.
- R4: Word bits 23..18 have no effect on either output.
- R5: Raising frame-select before the 24th falling edge leaves the code and the mode unchanged and produces no update strobe.
- R6: After an aborted word, the next full word is decoded with no residue from the partial word.
- R7: Falling edges after the 24th, while frame-select stays low, change nothing and produce no strobe until frame-select goes high and then low again.
- R8: Every completed word produces exactly one update strobe, one system-clock cycle long.
- R9: The outputs do not change after 23 falling edges. They change only after the 24th, while frame-select is still low.
- R10: Consecutive words, each framed by its own frame-select low period, each commit their own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_n | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Committed conversion code |
| pd_mode | output | 2 | Committed power-down mode, 00 = normal |
| update_stb | output | 1 | One-cycle pulse on each commit |

## Verification
The bench builds the block with its defaults: a 24-bit word, a 16-bit code, a 2-bit mode and two synchroniser stages, with the serial clock at one eighth of the system clock. With that setup it sweeps all four mode values against a walking-one code and several dense codes, using varying ignored top bits. It aborts a word after every edge count from 0 to 23. It also checks the 23rd and 24th edges separately, with extra edges after a full word in the same frame-select window.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

  // Receiver phase within one frame-select window
  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,   // frame-select high, nothing collected
    RX_SHIFT = 2'b01,   // collecting bits
    RX_FULL  = 2'b10    // word committed, waiting for frame-select high
  } rx_phase_e;

endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_async;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dac_rx_edge.sv
module dac_rx_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RST_LVL;
    else        level_q <= level;
  end

  assign fall = level_q & ~level;

  // A falling edge cannot be reported in two consecutive cycles
  AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R8

endmodule

// File: rtl/dac_rx_shifter.sv
module dac_rx_shifter
  import dac_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_hi,   // synchronised frame-select level
  input  logic                  bit_fall,   // serial clock falling edge
  input  logic                  bit_in,     // synchronised data bit
  output logic                  commit,
  output logic [FRAME_BITS-1:0] frame_word
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  rx_phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [FRAME_BITS-1:0] word_next;
  logic                  reg_en;

  assign word_next = {sh_q[FRAME_BITS-2:0], bit_in};
  assign reg_en    = frame_hi | bit_fall | (phase_q == RX_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    commit  = 1'b0;
    if (frame_hi) begin
      phase_d = RX_IDLE;
      cnt_d   = '0;
      sh_d    = '0;
    end else begin
      unique case (phase_q)
        RX_IDLE, RX_SHIFT: begin
          phase_d = RX_SHIFT;
          if (bit_fall) begin
            sh_d = word_next;
            if (cnt_q == LAST_IDX) begin
              commit  = 1'b1;
              phase_d = RX_FULL;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        RX_FULL: begin
          phase_d = RX_FULL;
        end
        default: begin
          phase_d = RX_IDLE;
          cnt_d   = '0;
          sh_d    = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (reg_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  assign frame_word = word_next;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX); // R9

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hi |=> (cnt_q == '0 && sh_q == '0 && phase_q == RX_IDLE)); // R6

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == RX_FULL && !frame_hi) |=> (phase_q == RX_FULL && !commit)); // R7

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int unsigned FRAME_BITS  = 24,
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned MODE_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsel_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [CODE_W-1:0] dac_code,
  output logic [MODE_W-1:0] pd_mode,
  output logic              update_stb
);

  localparam int unsigned MODE_LSB = CODE_W;
  localparam int unsigned MODE_MSB = CODE_W + MODE_W - 1;

  logic [2:0]            link_sync;
  logic                  fsel_s, sclk_s, sdata_s;
  logic                  sclk_fall;
  logic                  commit;
  logic [FRAME_BITS-1:0] word;

  logic [CODE_W-1:0] code_q, code_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              stb_q, stb_d;

  dac_rx_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({fsel_n, sclk, sdata}),
    .d_sync  (link_sync)
  );

  assign {fsel_s, sclk_s, sdata_s} = link_sync;

  dac_rx_edge #(
    .RST_LVL (1'b0)
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sclk_s),
    .fall  (sclk_fall)
  );

  dac_rx_shifter #(
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_hi   (fsel_s),
    .bit_fall   (sclk_fall),
    .bit_in     (sdata_s),
    .commit     (commit),
    .frame_word (word)
  );

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    stb_d  = commit;
    if (commit) begin
      code_d = word[CODE_W-1:0];
      mode_d = word[MODE_MSB:MODE_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
      stb_q  <= stb_d;
    end
  end

  assign dac_code   = code_q;
  assign pd_mode    = mode_q;
  assign update_stb = stb_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !update_stb); // R8

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_stb |-> $stable(dac_code)); // R5

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_stb |-> $stable(pd_mode)); // R5

  AST_STB_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |-> !$past(fsel_s)); // R5

endmodule

// File: tb/dac_frame_rx_test.sv
module dac_frame_rx_test;

  logic        clk;
  logic        rst_n;
  logic        fsel_n;
  logic        sclk;
  logic        sdata;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic        update_stb;

  int checks   = 0;
  int failures = 0;
  int stb_cnt  = 0;
  int stb_long = 0;
  bit stb_prev = 0;
  bit finished = 0;

  logic [15:0] exp_code;
  logic [1:0]  exp_mode;

  dac_frame_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsel_n     (fsel_n),
    .sclk       (sclk),
    .sdata      (sdata),
    .dac_code   (dac_code),
    .pd_mode    (pd_mode),
    .update_stb (update_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (update_stb) begin
      stb_cnt++;
      if (stb_prev) stb_long++;
    end
    stb_prev = update_stb;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(dac_code == exp_code, req, 32'(dac_code), 32'(exp_code));
    check(pd_mode  == exp_mode, req, 32'(pd_mode),  32'(exp_mode));
  endtask

  task automatic frame_start();
    @(negedge clk);
    fsel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_stop();
    fsel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // Shift bits hi down to lo, one serial-clock period (8 clk) each
  task automatic shift_bits(input logic [23:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      sdata = w[i];
      sclk  = 1'b1;
      repeat (4) @(negedge clk);
      sclk  = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(input logic [23:0] w);
    frame_start();
    shift_bits(w, 23, 0);
    frame_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    int          base;
    rst_n  = 1'b0;
    fsel_n = 1'b1;
    sclk   = 1'b0;
    sdata  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    exp_code = '0; exp_mode = '0;
    check_outputs("R1");
    check(update_stb == 1'b0 && stb_cnt == 0, "R1", 32'(stb_cnt), 0);

    // R2 R3 R4 R8: every mode against walking-one and dense codes
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 20; k++) begin
        logic [15:0] c;
        if (k < 16)       c = 16'(1) << k;
        else if (k == 16) c = 16'h0000;
        else if (k == 17) c = 16'hFFFF;
        else if (k == 18) c = 16'hA5C3;
        else              c = 16'(16'h1357 * (m + 3));
        w = {6'((m * 20 + k) * 37 + 5), 2'(m), c};
        base = stb_cnt;
        send_word(w);
        exp_code = w[15:0];
        exp_mode = w[17:16];
        check(dac_code == exp_code, "R2", 32'(dac_code), 32'(exp_code));
        check(pd_mode  == exp_mode, "R3", 32'(pd_mode),  32'(exp_mode));
        check(stb_cnt == base + 1, "R8", 32'(stb_cnt - base), 1);
      end
    end

    // R4: same payload with opposite top bits gives the same outputs
    send_word({6'b000000, 2'b01, 16'h0F0F});
    send_word({6'b111111, 2'b10, 16'h3C3C});
    exp_code = 16'h3C3C; exp_mode = 2'b10;
    check_outputs("R4");
    send_word({6'b101010, 2'b10, 16'h3C3C});
    check_outputs("R4");

    // R5 R6: abort after every edge count 0..23, then a clean word
    for (int n = 0; n < 24; n++) begin
      base = stb_cnt;
      frame_start();
      if (n > 0) shift_bits(24'hFFFFFF, 23, 24 - n);
      frame_stop();
      check(dac_code == exp_code, "R5", 32'(dac_code), 32'(exp_code));
      check(pd_mode  == exp_mode, "R5", 32'(pd_mode),  32'(exp_mode));
      check(stb_cnt == base, "R5", 32'(stb_cnt - base), 0);
      if (n % 4 == 3) begin
        w = {6'h15, 2'(n), 16'(n * 16'h0301)};
        send_word(w);
        exp_code = w[15:0]; exp_mode = w[17:16];
        check_outputs("R6");
      end
    end

    // R9 R7: commit only on the 24th edge; later edges ignored
    w = {6'h2A, 2'b11, 16'hBEEF};
    base = stb_cnt;
    frame_start();
    shift_bits(w, 23, 1);
    check_outputs("R9");
    check(stb_cnt == base, "R9", 32'(stb_cnt - base), 0);
    shift_bits(w, 0, 0);
    exp_code = 16'hBEEF; exp_mode = 2'b11;
    check_outputs("R9");
    check(stb_cnt == base + 1, "R9", 32'(stb_cnt - base), 1);
    shift_bits(24'h00_1234, 23, 0);
    check_outputs("R7");
    check(stb_cnt == base + 1, "R7", 32'(stb_cnt - base), 1);
    frame_stop();

    // R10: back-to-back words each commit
    for (int j = 0; j < 4; j++) begin
      w = {6'h0, 2'(3 - j), 16'(16'h1111 * (j + 1))};
      send_word(w);
      exp_code = w[15:0]; exp_mode = w[17:16];
      check_outputs("R10");
    end

    // R8: strobe never wider than one cycle
    check(stb_long == 0, "R8", 32'(stb_long), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule